// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block moves one 8-bit word at a time over a three-wire clocked serial link. It sends and receives together: while the word held in the transmit shift register goes out on the data output, the data input is shifted into a receive register. A configuration bit picks the role. As master, the block makes the serial clock from the bus clock through a programmable divider and drives the clock pin. As slave, it takes an external clock, passes it through a two-flop synchroniser, and finds its edges in the bus clock domain.

The polarity bit sets the idle level of the serial clock. It also decides which edge launches data and which edge samples it. The edge that leaves the idle level always launches the next bit. The edge that returns to idle always samples. A second bit picks whether the most or the least significant bit goes first, and that order holds for both directions. When a transfer ends, the clock goes back to its idle level and the data output keeps the last bit it sent. A done flag and, in master mode only, a one-cycle DMA request strobe mark the end of each word.

Top module: `sync_serial_port`

## Requirements
- R1: A start pulse taken while idle sets busy at once. The transfer then makes exactly 8 launch edges and 8 sample edges, and busy clears on the eighth sample edge.
- R2: With cfg_pol = 0 the clock idles high. A bit is driven on sdo at each falling edge, and sdi is sampled at each rising edge.
- R3: With cfg_pol = 1 the clock idles low. A bit is driven on sdo at each rising edge, and sdi is sampled at each falling edge.
- R4: Outside a transfer, sclk_o sits at the idle level for the current polarity (high for cfg_pol = 0, low for cfg_pol = 1). sclk_oe equals cfg_master.
- R5: sdo changes only on a launch edge. After a transfer it holds the last bit sent until the next launch edge.
- R6: With cfg_msb_first = 1, bit 7 is sent and received first. With cfg_msb_first = 0, bit 0 comes first. rx_byte holds the received word with bits in their normal positions.
- R7: In master mode each clock half-period lasts max(cfg_div,1)+1 bus clocks, so a cfg_div of 0 acts like 1. Busy falls 16·(max(cfg_div,1)+1) bus clocks after the start edge.
- R8: In master mode, dma_req is high for exactly one cycle, in the cycle busy first reads low after a transfer. In slave mode it never goes high.
- R9: In slave mode, edges on sclk_i move the transfer, with the same edge roles and bit order as in master mode. The external half-period must be at least 4 bus clocks.
- R10: After reset, busy, done, dma_req and rx_byte are 0 and sdo is 1. done sets when busy falls at the end of a word, clears on the next accepted start, and is never high together with busy.
- R11: A start pulse during a transfer is ignored. The length, the word sent and the word received stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_pol | input | 1 | Clock polarity: 0 idles high, 1 idles low |
| cfg_msb_first | input | 1 | 1 sends and receives bit 7 first, 0 sends bit 0 first |
| cfg_div | input | DIV_W | Master half-period divider, in bus clocks minus one (0 acts as 1) |
| start | input | 1 | Starts one word transfer when idle |
| tx_byte | input | DATA_W | Word loaded for sending at start |
| rx_byte | output | DATA_W | Last word received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Set when a word completes, cleared on the next start |
| dma_req | output | 1 | One-cycle request at word end, master mode only |
| sclk_o | output | 1 | Serial clock output |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| sclk_i | input | 1 | External serial clock, used in slave mode |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |

## Verification
In master mode, every launch shows on sdo at the same bus edge where sclk_o leaves idle. Each sample takes sdi at the edge where sclk_o returns to idle. busy, done, rx_byte and dma_req all change at the 16·h-th edge after the start edge, where h is the half-period. The bench watches the pins at falling bus edges and counts those edges from the start pulse. It checks the busy, done and strobe results in the first such sample after that edge, and the strobe clearing one sample later. In slave mode the design reacts up to three bus cycles after an external edge. The bench therefore holds each external half-period for five cycles and reads sdo just before the next sampling edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Idle level of the serial clock for a polarity setting: 0 -> high, 1 -> low
  function automatic logic idle_lvl(input logic pol);
    return ~pol;
  endfunction
endpackage

// File: rtl/ssp_mclk.sv
module ssp_mclk #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pol,
  input  logic [DIV_W-1:0] div,
  output logic             sclk_q,
  output logic             lead,
  output logic             trail
);
  import ssp_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_m1;
  logic             tick;

  assign half_m1 = (div == '0) ? DIV_W'(1) : div;
  assign tick    = run && (cnt == half_m1);
  assign lead    = tick && (sclk_q == idle_lvl(pol));
  assign trail   = tick && (sclk_q != idle_lvl(pol));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      sclk_q <= idle_lvl(pol);
    end else if (tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !$past(run) && $stable(pol)) |-> (sclk_q == idle_lvl(pol)));
endmodule

// File: rtl/ssp_sedge.sv
module ssp_sedge (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pol,
  input  logic sclk_in,
  input  logic sdi_in,
  output logic lead,
  output logic trail,
  output logic sdi_s
);
  import ssp_pkg::*;

  logic c1, c2, c3;
  logic d1, d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      c1 <= idle_lvl(pol);
      c2 <= idle_lvl(pol);
      c3 <= idle_lvl(pol);
      d1 <= 1'b0;
      d2 <= 1'b0;
    end else begin
      c1 <= sclk_in;
      c2 <= c1;
      c3 <= c2;
      d1 <= sdi_in;
      d2 <= d1;
    end
  end

  assign sdi_s = d2;
  assign lead  = run && (c2 != idle_lvl(pol)) && (c3 == idle_lvl(pol));
  assign trail = run && (c2 == idle_lvl(pol)) && (c3 != idle_lvl(pol));

  // R9
  single_lead_chk: assert property (@(posedge clk) disable iff (rst)
    lead |=> !lead);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              msb_first,
  input  logic              master,
  input  logic              lead,
  input  logic              trail,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  output logic              dma_req
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] rx_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic              last;

  assign rx_next = msb_first ? {rx_sr[DATA_W-2:0], sdi} : {sdi, rx_sr[DATA_W-1:1]};
  assign last    = trail && (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      sdo     <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      dma_req <= 1'b0;
      if (load && !busy) begin
        tx_sr   <= tx_byte;
        bit_cnt <= '0;
        busy    <= 1'b1;
        done    <= 1'b0;
      end else if (busy) begin
        if (lead) begin
          sdo   <= msb_first ? tx_sr[DATA_W-1] : tx_sr[0];
          tx_sr <= msb_first ? (tx_sr << 1) : (tx_sr >> 1);
        end
        if (trail) begin
          rx_sr   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_next;
            dma_req <= master;
          end
        end
      end
    end
  end

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R10
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
  // R8
  dma_master_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (master && done && $fell(busy)));
  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(lead && busy) |=> $stable(sdo));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_pol,
  input  logic              cfg_msb_first,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  output logic              dma_req,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sclk_i,
  output logic              sdo,
  input  logic              sdi
);
  import ssp_pkg::*;

  logic m_sclk, m_lead, m_trail;
  logic s_lead, s_trail, s_sdi;
  logic lead, trail, sdi_use;

  ssp_mclk #(.DIV_W(DIV_W)) u_mclk (
    .clk    (clk),
    .rst    (rst),
    .run    (busy && cfg_master),
    .pol    (cfg_pol),
    .div    (cfg_div),
    .sclk_q (m_sclk),
    .lead   (m_lead),
    .trail  (m_trail)
  );

  ssp_sedge u_sedge (
    .clk     (clk),
    .rst     (rst),
    .run     (busy && !cfg_master),
    .pol     (cfg_pol),
    .sclk_in (sclk_i),
    .sdi_in  (sdi),
    .lead    (s_lead),
    .trail   (s_trail),
    .sdi_s   (s_sdi)
  );

  assign lead    = cfg_master ? m_lead  : s_lead;
  assign trail   = cfg_master ? m_trail : s_trail;
  assign sdi_use = cfg_master ? sdi     : s_sdi;

  ssp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .tx_byte   (tx_byte),
    .msb_first (cfg_msb_first),
    .master    (cfg_master),
    .lead      (lead),
    .trail     (trail),
    .sdi       (sdi_use),
    .sdo       (sdo),
    .rx_byte   (rx_byte),
    .busy      (busy),
    .done      (done),
    .dma_req   (dma_req)
  );

  assign sclk_o  = cfg_master ? m_sclk : idle_lvl(cfg_pol);
  assign sclk_oe = cfg_master;
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_master = 1'b1, cfg_pol = 1'b0, cfg_msb_first = 1'b0;
  logic [3:0] cfg_div = 4'd1;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic       busy, done, dma_req, sclk_o, sclk_oe, sdo;
  logic       sclk_i = 1'b1, sdi = 1'b0;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  sync_serial_port #(.DATA_W(8), .DIV_W(4)) dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
    .cfg_msb_first(cfg_msb_first), .cfg_div(cfg_div), .start(start),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy), .done(done),
    .dma_req(dma_req), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_master(input logic pol, input logic msb, input int dv,
                            input logic [7:0] tx, input logic [7:0] pat, input bit poke);
    int   h = ((dv == 0) ? 1 : dv) + 1;
    logic idle = ~pol;
    logic prev;
    logic [7:0] cap = 8'h00;
    int   k, nl = 0, nt = 0;
    @(negedge clk);
    cfg_master = 1'b1; cfg_pol = pol; cfg_msb_first = msb; cfg_div = 4'(dv);
    sclk_i = idle; sdi = 1'b0;
    @(negedge clk);
    chk("R4 idle clock before start", {31'd0, sclk_o}, {31'd0, idle});
    start = 1'b1; tx_byte = tx;
    @(negedge clk);
    start = 1'b0; k = 1;
    chk("R10 start sets busy, clears done", {30'd0, busy, done}, 32'h2);
    prev = sclk_o;
    while (busy && k < 5000) begin
      if (sclk_o !== prev) begin
        if (prev === idle) begin
          int bi = msb ? 7 - nl : nl;
          cap[bi] = sdo;
          sdi = pat[bi];
          nl++;
        end else begin
          nt++;
        end
        prev = sclk_o;
      end
      start = (poke && k == 5);
      if (poke && k == 5) tx_byte = ~tx;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    if (sclk_o !== prev) nt++;
    chk("R7 busy length in bus clocks", k - 1, 16 * h);
    chk("R1 launch and sample edge counts", {nl[15:0], nt[15:0]}, {16'd8, 16'd8});
    if (pol) chk("R3 word seen on sdo at rising edges", {24'd0, cap}, {24'd0, tx});
    else     chk("R2 word seen on sdo at falling edges", {24'd0, cap}, {24'd0, tx});
    chk("R6 received word order", {24'd0, rx_byte}, {24'd0, pat});
    chk("R10 done after word", {30'd0, busy, done}, 32'h1);
    chk("R8 dma strobe at end in master", {31'd0, dma_req}, 32'd1);
    chk("R4 clock parked at idle, oe on", {30'd0, sclk_o, sclk_oe}, {30'd0, idle, 1'b1});
    chk("R5 last bit held on sdo", {31'd0, sdo}, {31'd0, msb ? tx[0] : tx[7]});
    if (poke) chk("R11 start during transfer ignored", {23'd0, (cap == tx) && (rx_byte == pat), 8'd0}, 32'h100);
    @(negedge clk);
    chk("R8 dma strobe lasts one cycle", {31'd0, dma_req}, 32'd0);
    chk("R5 sdo still held", {31'd0, sdo}, {31'd0, msb ? tx[0] : tx[7]});
  endtask

  task automatic run_slave(input logic pol, input logic msb,
                           input logic [7:0] tx, input logic [7:0] pat);
    logic idle = ~pol;
    logic [7:0] cap = 8'h00;
    bit   dma_seen = 1'b0;
    @(negedge clk);
    cfg_master = 1'b0; cfg_pol = pol; cfg_msb_first = msb; sclk_i = idle;
    repeat (4) @(negedge clk);
    start = 1'b1; tx_byte = tx;
    @(negedge clk);
    start = 1'b0;
    chk("R10 slave start sets busy", {30'd0, busy, done}, 32'h2);
    for (int i = 0; i < 8; i++) begin
      int bi = msb ? 7 - i : i;
      sclk_i = ~idle; sdi = pat[bi];
      repeat (5) begin @(negedge clk); dma_seen |= dma_req; end
      cap[bi] = sdo;
      sclk_i = idle;
      repeat (5) begin @(negedge clk); dma_seen |= dma_req; end
    end
    chk("R9 slave word driven on sdo", {24'd0, cap}, {24'd0, tx});
    chk("R9 slave word received", {24'd0, rx_byte}, {24'd0, pat});
    chk("R10 slave done after word", {30'd0, busy, done}, 32'h1);
    chk("R8 no dma strobe in slave", {31'd0, dma_seen}, 32'd0);
    chk("R4 slave clock not driven", {31'd0, sclk_oe}, 32'd0);
    chk("R5 slave last bit held", {31'd0, sdo}, {31'd0, msb ? tx[0] : tx[7]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset state", {21'd0, busy, done, dma_req, rx_byte}, 32'd0);
    chk("R10 reset sdo", {31'd0, sdo}, 32'd1);
    chk("R4 reset idle clock", {30'd0, sclk_o, sclk_oe}, 32'h3);
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 4; d++)
          for (int n = 0; n < 3; n++) begin
            int idx = ((p * 2 + m) * 4 + d) * 3 + n;
            run_master(p[0], m[0], d, 8'(8'hA5 ^ (idx * 37)), 8'(idx * 91 + 3), 1'b0);
          end
    run_master(1'b0, 1'b1, 2, 8'h3C, 8'hC6, 1'b1);
    run_master(1'b1, 1'b0, 0, 8'h81, 8'h5A, 1'b1);
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int n = 0; n < 2; n++) begin
          int idx = (p * 2 + m) * 2 + n;
          run_slave(p[0], m[0], 8'(8'h1E + idx * 53), 8'(8'hE1 ^ (idx * 29)));
        end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule